// File: doc/BRIEF.md
# SCSI Bus Protocol Register Interface

This block is the host-facing register file of a parallel SCSI bus controller. Eight byte-wide registers sit on a 3-bit address. A host uses a simple synchronous strobe bus to program which bus lines the controller asserts. Through the same bus it reads back the live state of every bus line. Several addresses mean one thing when read and another when written. Writes to three addresses carry no data and only start a DMA transfer in one of three directions.

On the bus side, each line is modelled as an active-high input plus an active-high output enable. This covers the data byte, its parity, and the nine control lines. The block compares the bus phase against the phase programmed for the target and reports the result as a flag. It drives the data byte only when the programmed role and phase allow it. In DMA mode it latches incoming bytes on the falling edge of the handshake strobe. A single interrupt output covers selection, parity error, end of DMA and unexpected loss of BSY. A read of the clear address acknowledges all of these at once.

Bus inputs are registered once before use. Host reads return their data in the cycle after the read strobe. All bus output enables are registered.

Top module: `scsi_bus_regs`

## Requirements
- R1: After reset, the read data, all bus output enables, `diff_en_o`, `drq_o`, `irq_o` and the DMA start pulses are 0.
- R2: Address 1 reads back the written controls at bits 7 (RST), 4 (ACK), 3 (BSY), 2 (SEL), 1 (ATN) and 0 (drive data). On read, bit 6 is arbitration-in-progress (mode bit 0) and bit 5 is arbitration-lost (mode bit 0 set, bus SEL active, own SEL control clear). Address 2 reads back all eight mode bits. Address 3 reads back bits 3..0, and its bit 7 is the read-only last-byte-sent flag.
- R3: A read of address 4 returns the bus lines, bit 7 to bit 0: RST, BSY, REQ, MSG, CD, IO, SEL, data parity. A 1 means the line is active.
- R4: Address 5 read bits are: 7 end-of-DMA, 6 DMA request, 5 parity error, 4 interrupt, 3 phase match, 2 busy error, 1 ATN, 0 ACK. Bit 3 is 1 exactly when bus {MSG,CD,IO} equals address-3 bits 2..0. The phase codes are data out 000, data in 001, command 010, status 011, message out 110, message in 111.
- R5: `bus_ctl_oe` is indexed 8 RST, 7 BSY, 6 REQ, 5 ACK, 4 MSG, 3 CD, 2 IO, 1 SEL, 0 ATN. RST, BSY and SEL follow their controls in address 1. ACK and ATN follow address 1 only in initiator mode (mode bit 6 clear). REQ, MSG, CD and IO follow address-3 bits 3..0 only in target mode.
- R6: `bus_data_oe` is set in either of two cases. The first is arbitration (mode bit 0). The second is the drive-data control set while the phase permits output: in target mode, address-3 bit 0 is set; in initiator mode, that bit is clear and the phase matches. `bus_data_o` is the byte last written to address 0, and `bus_par_o` makes the total count of ones odd.
- R7: Writing bit 6 of address 1 forces every output enable to 0. Bit 5 of that write drives `diff_en_o`.
- R8: When bus BSY is inactive, SEL is active, and a bus data bit is set that is also set in the mask written to address 4, the interrupt is raised.
- R9: Any write to address 5, 6 or 7 gives a one-cycle pulse on `dma_send_o`, `dma_trecv_o` or `dma_irecv_o` respectively. Only one pulse is active at a time.
- R10: A DMA receive is started with mode bit 1 set. Each falling edge of REQ (initiator) or ACK (target) then latches the bus byte into address 6 and sets the DMA request. A read of address 6 clears that request.
- R11: With mode bit 2 set, a falling BSY line sets the busy error and raises the interrupt.
- R12: A read of address 7 clears the interrupt, parity error and busy error. An event arriving in the same cycle as that read wins.
- R13: With mode bit 5 set, a DMA byte latched with even overall parity sets the parity error. With mode bit 4 also set, it raises the interrupt.
- R14: During an initiator DMA, loss of phase match sets the end-of-DMA flag. It raises the interrupt if mode bit 3 is set. If the transfer was a send, it also sets the last-byte-sent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| bus_data_i | input | 8 | Bus data lines, active high |
| bus_par_i | input | 1 | Bus data parity line |
| bus_ctl_i | input | 9 | Bus control lines, indexed as in R5 |
| bus_data_o | output | 8 | Byte to drive on the data lines |
| bus_par_o | output | 1 | Odd parity of bus_data_o |
| bus_data_oe | output | 1 | Data and parity output enable |
| bus_ctl_oe | output | 9 | Control line output enables |
| diff_en_o | output | 1 | Differential driver enable |
| dma_send_o | output | 1 | DMA send start pulse |
| dma_trecv_o | output | 1 | Target DMA receive start pulse |
| dma_irecv_o | output | 1 | Initiator DMA receive start pulse |
| drq_o | output | 1 | DMA request |
| irq_o | output | 1 | Interrupt |

## Verification
A host read of the clear address and a fresh interrupt event can land on the same clock edge. When they do, the event must survive. The bench drops BSY with busy monitoring enabled. It waits exactly one cycle for the bus input register to take the new level, then issues the clearing read so that its edge coincides with the busy-error update. The bench judges the result by checking that the interrupt output and the busy-error bit at address 5 are still set after the read.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  // register addresses; read and write meanings differ at several of them
  localparam logic [AW-1:0] A_DATA   = 3'd0;
  localparam logic [AW-1:0] A_ICMD   = 3'd1;
  localparam logic [AW-1:0] A_MODE   = 3'd2;
  localparam logic [AW-1:0] A_TCMD   = 3'd3;
  localparam logic [AW-1:0] A_STAT   = 3'd4;
  localparam logic [AW-1:0] A_BSTAT  = 3'd5;
  localparam logic [AW-1:0] A_INDATA = 3'd6;
  localparam logic [AW-1:0] A_CLR    = 3'd7;

  // control line vector indices
  localparam int NCTL  = 9;
  localparam int L_ATN = 0;
  localparam int L_SEL = 1;
  localparam int L_IO  = 2;
  localparam int L_CD  = 3;
  localparam int L_MSG = 4;
  localparam int L_ACK = 5;
  localparam int L_REQ = 6;
  localparam int L_BSY = 7;
  localparam int L_RST = 8;

  typedef struct packed {
    logic blk_dma;
    logic target;
    logic par_chk;
    logic par_irq;
    logic eop_irq;
    logic mon_bsy;
    logic dma;
    logic arb;
  } mode_t;

  typedef struct packed {
    logic rst;
    logic ack;
    logic bsy;
    logic sel;
    logic atn;
    logic dout;
  } icmd_t;
endpackage

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] out_data,
  output icmd_t             icmd,
  output logic              tri_en,
  output logic              diff_en,
  output mode_t             mode,
  output logic [3:0]        tcmd,
  output logic [DATA_W-1:0] sel_mask,
  output logic              start_send,
  output logic              start_trecv,
  output logic              start_irecv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data    <= '0;
      icmd        <= '0;
      tri_en      <= 1'b0;
      diff_en     <= 1'b0;
      mode        <= '0;
      tcmd        <= '0;
      sel_mask    <= '0;
      start_send  <= 1'b0;
      start_trecv <= 1'b0;
      start_irecv <= 1'b0;
    end else begin
      start_send  <= wr_en && (addr == A_BSTAT);
      start_trecv <= wr_en && (addr == A_INDATA);
      start_irecv <= wr_en && (addr == A_CLR);
      if (wr_en) begin
        case (addr)
          A_DATA: out_data <= wdata;
          A_ICMD: begin
            icmd    <= '{rst: wdata[7], ack: wdata[4], bsy: wdata[3],
                         sel: wdata[2], atn: wdata[1], dout: wdata[0]};
            tri_en  <= wdata[6];
            diff_en <= wdata[5];
          end
          A_MODE: mode     <= mode_t'(wdata[7:0]);
          A_TCMD: tcmd     <= wdata[3:0];
          A_STAT: sel_mask <= wdata;
          default: ;
        endcase
      end
    end
  end

  // R9: start pulses never overlap
  a_r9_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_send, start_trecv, start_irecv}));

  // R9: a write to the send address yields a pulse next cycle
  a_r9_send_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_BSTAT) |=> (start_send && !start_irecv));
endmodule

// File: rtl/scsi_bus_drive.sv
module scsi_bus_drive
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int N_CTL  = NCTL
) (
  input  logic              clk,
  input  logic              rst,
  input  icmd_t             icmd,
  input  logic              tri_en,
  input  logic              target,
  input  logic              arb,
  input  logic [3:0]        tcmd,
  input  logic [DATA_W-1:0] out_data,
  input  logic              phase_match,
  output logic [N_CTL-1:0]  ctl_oe,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              par_o
);
  logic [N_CTL-1:0] ctl_nx;
  logic             dout_ok;
  logic             data_nx;

  always_comb begin
    ctl_nx        = '0;
    ctl_nx[L_RST] = icmd.rst;
    ctl_nx[L_BSY] = icmd.bsy;
    ctl_nx[L_SEL] = icmd.sel;
    ctl_nx[L_ACK] = icmd.ack & ~target;
    ctl_nx[L_ATN] = icmd.atn & ~target;
    ctl_nx[L_REQ] = tcmd[3] & target;
    ctl_nx[L_MSG] = tcmd[2] & target;
    ctl_nx[L_CD]  = tcmd[1] & target;
    ctl_nx[L_IO]  = tcmd[0] & target;
    // a target sends when IO is set; an initiator when IO is clear and phase agrees
    dout_ok = target ? tcmd[0] : (~tcmd[0] & phase_match);
    data_nx = arb | (icmd.dout & dout_ok);
    if (tri_en) begin
      ctl_nx  = '0;
      data_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_oe  <= '0;
      data_oe <= 1'b0;
      data_o  <= '0;
      par_o   <= 1'b1;
    end else begin
      ctl_oe  <= ctl_nx;
      data_oe <= data_nx;
      data_o  <= out_data;
      par_o   <= ~(^out_data);
    end
  end

  // R7: tri-state request silences every driver on the next edge
  a_r7_tristate: assert property (@(posedge clk) disable iff (rst)
    tri_en |=> (ctl_oe == '0 && !data_oe));

  // R5: a target never drives ACK
  a_r5_no_ack_tgt: assert property (@(posedge clk) disable iff (rst)
    target |=> !ctl_oe[L_ACK]);
endmodule

// File: rtl/scsi_event_ctl.sv
module scsi_event_ctl
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_target,
  input  logic              m_dma,
  input  logic              m_par_chk,
  input  logic              m_par_irq,
  input  logic              m_eop_irq,
  input  logic              m_mon_bsy,
  input  logic [DATA_W-1:0] sel_mask,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              bsy,
  input  logic              sel,
  input  logic              req,
  input  logic              ack,
  input  logic              phase_match,
  input  logic              start_send,
  input  logic              start_trecv,
  input  logic              start_irecv,
  input  logic              rd_indata,
  input  logic              rd_clr,
  input  logic              wr_data,
  output logic [DATA_W-1:0] in_latch,
  output logic              drq,
  output logic              irq,
  output logic              par_err,
  output logic              busy_err,
  output logic              end_dma,
  output logic              last_sent
);
  logic bsy_d, req_d, ack_d, pm_d, selhit_d;
  logic dma_act, dma_snd;
  logic [DATA_W-1:0] sel_bits;

  for (genvar g = 0; g < DATA_W; g++) begin : g_selbit
    assign sel_bits[g] = bus_data[g] & sel_mask[g];
  end

  logic start_any, strobe_fall, capture, par_ev, eop_ev, busy_ev;
  logic sel_hit, sel_ev, irq_set, drq_set, drq_clr;

  always_comb begin
    start_any   = start_send | start_trecv | start_irecv;
    strobe_fall = m_target ? (ack_d & ~ack) : (req_d & ~req);
    capture     = dma_act & ~dma_snd & strobe_fall;
    par_ev      = capture & m_par_chk & ~(^{bus_par, bus_data});
    eop_ev      = dma_act & ~m_target & pm_d & ~phase_match;
    busy_ev     = m_mon_bsy & bsy_d & ~bsy;
    sel_hit     = ~bsy & sel & (|sel_bits);
    sel_ev      = sel_hit & ~selhit_d;
    irq_set     = sel_ev | busy_ev | (par_ev & m_par_irq) | (eop_ev & m_eop_irq);
    drq_set     = (start_send & m_dma) | (dma_act & strobe_fall);
    drq_clr     = dma_snd ? wr_data : rd_indata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy_d    <= 1'b0;
      req_d    <= 1'b0;
      ack_d    <= 1'b0;
      pm_d     <= 1'b0;
      selhit_d <= 1'b0;
    end else begin
      bsy_d    <= bsy;
      req_d    <= req;
      ack_d    <= ack;
      pm_d     <= phase_match;
      selhit_d <= sel_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_act   <= 1'b0;
      dma_snd   <= 1'b0;
      end_dma   <= 1'b0;
      last_sent <= 1'b0;
    end else if (start_any && m_dma) begin
      dma_act   <= 1'b1;
      dma_snd   <= start_send;
      end_dma   <= 1'b0;
      last_sent <= 1'b0;
    end else begin
      if (!m_dma) dma_act <= 1'b0;
      if (eop_ev) begin
        end_dma <= 1'b1;
        if (dma_snd) last_sent <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_latch <= '0;
      drq      <= 1'b0;
    end else begin
      if (capture) in_latch <= bus_data;
      if (!m_dma)       drq <= 1'b0;
      else if (drq_set) drq <= 1'b1;
      else if (drq_clr) drq <= 1'b0;
    end
  end

  // flags: a new event beats the clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      par_err  <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      if (irq_set)     irq <= 1'b1;
      else if (rd_clr) irq <= 1'b0;
      if (par_ev)      par_err <= 1'b1;
      else if (rd_clr) par_err <= 1'b0;
      if (busy_ev)     busy_err <= 1'b1;
      else if (rd_clr) busy_err <= 1'b0;
    end
  end

  // R11: a monitored BSY drop is flagged and interrupts
  a_r11_busy_err: assert property (@(posedge clk) disable iff (rst)
    (m_mon_bsy && bsy_d && !bsy) |=> (busy_err && irq));

  // R12: the clearing read drops the interrupt unless a new event arrived
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !irq_set) |=> !irq);

  // R10: no DMA request outside DMA mode
  a_r10_drq_mode: assert property (@(posedge clk) disable iff (rst)
    !m_dma |=> !drq);
endmodule

// File: rtl/scsi_bus_regs.sv
module scsi_bus_regs
  import scsi_regs_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW,
  parameter int N_CTL  = NCTL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_par_i,
  input  logic [N_CTL-1:0]  bus_ctl_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_par_o,
  output logic              bus_data_oe,
  output logic [N_CTL-1:0]  bus_ctl_oe,
  output logic              diff_en_o,
  output logic              dma_send_o,
  output logic              dma_trecv_o,
  output logic              dma_irecv_o,
  output logic              drq_o,
  output logic              irq_o
);
  // registered bus sample
  logic [DATA_W-1:0] s_data;
  logic              s_par;
  logic [N_CTL-1:0]  s_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_data <= '0;
      s_par  <= 1'b0;
      s_ctl  <= '0;
    end else begin
      s_data <= bus_data_i;
      s_par  <= bus_par_i;
      s_ctl  <= bus_ctl_i;
    end
  end

  logic [DATA_W-1:0] out_data, sel_mask, in_latch;
  icmd_t             icmd;
  mode_t             mode;
  logic [3:0]        tcmd;
  logic              tri_en;
  logic              phase_match;
  logic              par_err, busy_err, end_dma, last_sent;

  assign phase_match = ({s_ctl[L_MSG], s_ctl[L_CD], s_ctl[L_IO]} == tcmd[2:0]);

  scsi_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(host_wr), .addr(host_addr), .wdata(host_wdata),
    .out_data(out_data), .icmd(icmd), .tri_en(tri_en), .diff_en(diff_en_o),
    .mode(mode), .tcmd(tcmd), .sel_mask(sel_mask),
    .start_send(dma_send_o), .start_trecv(dma_trecv_o), .start_irecv(dma_irecv_o)
  );

  scsi_bus_drive #(.DATA_W(DATA_W), .N_CTL(N_CTL)) u_drive (
    .clk(clk), .rst(rst), .icmd(icmd), .tri_en(tri_en), .target(mode.target),
    .arb(mode.arb), .tcmd(tcmd), .out_data(out_data), .phase_match(phase_match),
    .ctl_oe(bus_ctl_oe), .data_oe(bus_data_oe), .data_o(bus_data_o), .par_o(bus_par_o)
  );

  scsi_event_ctl #(.DATA_W(DATA_W)) u_evt (
    .clk(clk), .rst(rst),
    .m_target(mode.target), .m_dma(mode.dma), .m_par_chk(mode.par_chk),
    .m_par_irq(mode.par_irq), .m_eop_irq(mode.eop_irq), .m_mon_bsy(mode.mon_bsy),
    .sel_mask(sel_mask), .bus_data(s_data), .bus_par(s_par),
    .bsy(s_ctl[L_BSY]), .sel(s_ctl[L_SEL]), .req(s_ctl[L_REQ]), .ack(s_ctl[L_ACK]),
    .phase_match(phase_match),
    .start_send(dma_send_o), .start_trecv(dma_trecv_o), .start_irecv(dma_irecv_o),
    .rd_indata(host_rd && host_addr == A_INDATA),
    .rd_clr(host_rd && host_addr == A_CLR),
    .wr_data(host_wr && host_addr == A_DATA),
    .in_latch(in_latch), .drq(drq_o), .irq(irq_o), .par_err(par_err),
    .busy_err(busy_err), .end_dma(end_dma), .last_sent(last_sent)
  );

  logic arb_busy, arb_lost;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    arb_busy = mode.arb;
    arb_lost = mode.arb & s_ctl[L_SEL] & ~icmd.sel;
    case (host_addr)
      A_DATA:   rd_mux = s_data;
      A_ICMD:   rd_mux = {icmd.rst, arb_busy, arb_lost, icmd.ack,
                          icmd.bsy, icmd.sel, icmd.atn, icmd.dout};
      A_MODE:   rd_mux = mode;
      A_TCMD:   rd_mux = {last_sent, 3'b000, tcmd};
      A_STAT:   rd_mux = {s_ctl[L_RST], s_ctl[L_BSY], s_ctl[L_REQ], s_ctl[L_MSG],
                          s_ctl[L_CD], s_ctl[L_IO], s_ctl[L_SEL], s_par};
      A_BSTAT:  rd_mux = {end_dma, drq_o, par_err, irq_o, phase_match,
                          busy_err, s_ctl[L_ATN], s_ctl[L_ACK]};
      A_INDATA: rd_mux = in_latch;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // R4: the interrupt bit read at address 5 mirrors the interrupt pin
  a_r4_irq_mirror: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_BSTAT) |=> (host_rdata[4] == $past(irq_o)));

  // R2: mode register reads back what was written
  a_r2_mode_rb: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_MODE) |=> (mode == $past(host_wdata)));
endmodule

// File: tb/test_scsi_bus_regs.sv
`timescale 1ns/1ps
module test_scsi_bus_regs;
  localparam int B_ATN = 0, B_SEL = 1, B_IO = 2, B_CD = 3, B_MSG = 4,
                 B_ACK = 5, B_REQ = 6, B_BSY = 7, B_RST = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [7:0] bus_data_i = '0;
  logic       bus_par_i = 1'b0;
  logic [8:0] bus_ctl_i = '0;
  logic [7:0] bus_data_o;
  logic       bus_par_o, bus_data_oe;
  logic [8:0] bus_ctl_oe;
  logic       diff_en_o, dma_send_o, dma_trecv_o, dma_irecv_o, drq_o, irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scsi_bus_regs i_scsi_bus_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_data_i(bus_data_i), .bus_par_i(bus_par_i), .bus_ctl_i(bus_ctl_i),
    .bus_data_o(bus_data_o), .bus_par_o(bus_par_o), .bus_data_oe(bus_data_oe),
    .bus_ctl_oe(bus_ctl_oe), .diff_en_o(diff_en_o), .dma_send_o(dma_send_o),
    .dma_trecv_o(dma_trecv_o), .dma_irecv_o(dma_irecv_o), .drq_o(drq_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic idle();
    logic [7:0] d;
    wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    bus_ctl_i = '0; bus_data_i = '0; bus_par_i = 1'b0;
    settle(3);
    rd(3'd7, d);
    settle(1);
  endtask

  task automatic t_reset();
    chk("R1 rdata", {8'h0, host_rdata}, 16'h0);
    chk("R1 ctl_oe", {7'h0, bus_ctl_oe}, 16'h0);
    chk("R1 flags", {10'h0, bus_data_oe, diff_en_o, drq_o, irq_o, dma_send_o, dma_irecv_o}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    idle();
    wr(3'd1, 8'h1E); rd(3'd1, d); chk("R2 icmd readback", {8'h0, d}, 16'h001E);
    wr(3'd2, 8'h80); rd(3'd2, d); chk("R2 mode readback", {8'h0, d}, 16'h0080);
    wr(3'd3, 8'h8F); rd(3'd3, d); chk("R2 tcmd readback", {8'h0, d}, 16'h000F);
    wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    bus_ctl_i[B_SEL] = 1'b1; settle(3);
    rd(3'd1, d); chk("R2 arbitration bits", {8'h0, d}, 16'h0060);
  endtask

  task automatic t_status();
    logic [7:0] d;
    idle();
    bus_ctl_i[B_RST] = 1; bus_ctl_i[B_REQ] = 1; bus_ctl_i[B_CD] = 1; bus_ctl_i[B_SEL] = 1;
    bus_par_i = 1;
    settle(3);
    rd(3'd4, d); chk("R3 status order", {8'h0, d}, 16'h00AB);
  endtask

  task automatic t_phase();
    logic [7:0] d;
    idle();
    wr(3'd3, 8'h06);
    bus_ctl_i[B_MSG] = 1; bus_ctl_i[B_CD] = 1; settle(3);
    rd(3'd5, d); chk("R4 phase match msg out", {15'h0, d[3]}, 16'h1);
    bus_ctl_i[B_IO] = 1; settle(3);
    rd(3'd5, d); chk("R4 phase mismatch", {15'h0, d[3]}, 16'h0);
  endtask

  task automatic t_drive();
    idle();
    wr(3'd1, 8'h1E); settle(2);
    chk("R5 initiator drive", {7'h0, bus_ctl_oe}, 16'h00A3);
    wr(3'd2, 8'h40); wr(3'd3, 8'h0F); settle(2);
    chk("R5 target drive", {7'h0, bus_ctl_oe}, 16'h00DE);
  endtask

  task automatic t_data();
    idle();
    wr(3'd0, 8'h5A); wr(3'd2, 8'h40); wr(3'd3, 8'h01); wr(3'd1, 8'h01); settle(2);
    chk("R6 target data in", {7'h0, bus_data_oe, bus_data_o}, 16'h015A);
    chk("R6 parity odd", {15'h0, bus_par_o}, 16'h1);
    wr(3'd3, 8'h00); settle(2);
    chk("R6 target data out", {15'h0, bus_data_oe}, 16'h0);
    wr(3'd2, 8'h00); settle(3);
    chk("R6 initiator matched", {15'h0, bus_data_oe}, 16'h1);
    bus_ctl_i[B_MSG] = 1; settle(3);
    chk("R6 initiator mismatch", {15'h0, bus_data_oe}, 16'h0);
    wr(3'd1, 8'h00); wr(3'd2, 8'h01); settle(2);
    chk("R6 arbitration drives", {15'h0, bus_data_oe}, 16'h1);
  endtask

  task automatic t_tri();
    idle();
    wr(3'd1, 8'h48); settle(2);
    chk("R7 tri-state", {7'h0, bus_ctl_oe}, 16'h0);
    wr(3'd1, 8'h28); settle(2);
    chk("R7 differential", {6'h0, diff_en_o, bus_ctl_oe}, 16'h0280);
  endtask

  task automatic t_sel();
    logic [7:0] d;
    idle();
    wr(3'd4, 8'h08);
    bus_data_i = 8'h08; bus_ctl_i[B_SEL] = 1; settle(3);
    chk("R8 selection irq", {15'h0, irq_o}, 16'h1);
    rd(3'd5, d); chk("R4 irq bit mirror", {15'h0, d[4]}, 16'h1);
    rd(3'd7, d); settle(1);
    chk("R12 clear irq", {15'h0, irq_o}, 16'h0);
    bus_ctl_i[B_SEL] = 0; settle(3);
    bus_data_i = 8'h04; bus_ctl_i[B_SEL] = 1; settle(3);
    chk("R8 unmasked id ignored", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_start();
    wr(3'd5, 8'h00); chk("R9 send pulse", {13'h0, dma_send_o, dma_trecv_o, dma_irecv_o}, 16'h4);
    settle(1);       chk("R9 pulse width", {13'h0, dma_send_o, dma_trecv_o, dma_irecv_o}, 16'h0);
    wr(3'd6, 8'h33); chk("R9 target recv pulse", {13'h0, dma_send_o, dma_trecv_o, dma_irecv_o}, 16'h2);
    wr(3'd7, 8'hFF); chk("R9 initiator recv pulse", {13'h0, dma_send_o, dma_trecv_o, dma_irecv_o}, 16'h1);
  endtask

  task automatic t_recv();
    logic [7:0] d;
    idle();
    wr(3'd3, 8'h01); bus_ctl_i[B_IO] = 1; settle(3);
    wr(3'd2, 8'h32); wr(3'd7, 8'h00); settle(1);
    bus_data_i = 8'hC3; bus_par_i = 1; settle(1);
    bus_ctl_i[B_REQ] = 1; settle(3); bus_ctl_i[B_REQ] = 0; settle(3);
    chk("R10 drq after REQ fall", {15'h0, drq_o}, 16'h1);
    rd(3'd6, d); chk("R10 latched byte", {8'h0, d}, 16'h00C3);
    chk("R10 drq cleared by read", {15'h0, drq_o}, 16'h0);
    chk("R13 good parity no irq", {15'h0, irq_o}, 16'h0);
    bus_data_i = 8'h01; bus_par_i = 1; settle(1);
    bus_ctl_i[B_REQ] = 1; settle(3); bus_ctl_i[B_REQ] = 0; settle(3);
    chk("R13 parity irq", {15'h0, irq_o}, 16'h1);
    rd(3'd5, d); chk("R13 parity flag", {15'h0, d[5]}, 16'h1);
    rd(3'd7, d); rd(3'd5, d); chk("R12 parity cleared", {15'h0, d[5]}, 16'h0);
    idle();
    wr(3'd2, 8'h42); wr(3'd6, 8'h00); settle(1);
    bus_data_i = 8'h3C; settle(1);
    bus_ctl_i[B_ACK] = 1; settle(3); bus_ctl_i[B_ACK] = 0; settle(3);
    rd(3'd6, d); chk("R10 target ACK latch", {8'h0, d}, 16'h003C);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    idle();
    bus_ctl_i[B_BSY] = 1; wr(3'd2, 8'h04); settle(3);
    bus_ctl_i[B_BSY] = 0; settle(3);
    chk("R11 busy irq", {15'h0, irq_o}, 16'h1);
    rd(3'd5, d); chk("R11 busy flag", {15'h0, d[2]}, 16'h1);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    idle();
    bus_ctl_i[B_BSY] = 1; wr(3'd2, 8'h04); settle(3);
    rd(3'd7, d);
    bus_ctl_i[B_BSY] = 0; @(negedge clk);
    rd(3'd7, d);
    chk("R12 event wins over clear", {15'h0, irq_o}, 16'h1);
    rd(3'd5, d); chk("R12 busy flag kept", {15'h0, d[2]}, 16'h1);
  endtask

  task automatic t_eop();
    logic [7:0] d;
    idle();
    wr(3'd3, 8'h01); bus_ctl_i[B_IO] = 1; wr(3'd2, 8'h0A); settle(3);
    wr(3'd5, 8'h00); settle(2);
    bus_ctl_i[B_IO] = 0; settle(3);
    chk("R14 eop irq", {15'h0, irq_o}, 16'h1);
    rd(3'd5, d); chk("R14 end flag", {15'h0, d[7]}, 16'h1);
    rd(3'd3, d); chk("R14 last byte sent", {15'h0, d[7]}, 16'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    settle(2);
    t_regs();
    t_status();
    t_phase();
    t_drive();
    t_data();
    t_tri();
    t_sel();
    t_start();
    t_recv();
    t_busy();
    t_collide();
    t_eop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule